// File: doc/BRIEF.md
# I2C SCL Clock Phase Generator

This block produces the SCL waveform for an I2C controller from the system bus clock. A prescaler divides the bus clock by a power of two, 2^base. The phase sequencer then holds SCL low for a programmed number of prescaled ticks and releases it for another programmed number of ticks. Each phase field holds the phase length minus one, so a field of zero still gives one tick. One SCL period therefore lasts 2^base × ((high + 1) + (low + 1)) bus clocks.

The block does not drive the pad. It requests that SCL be pulled low, and it reads back the sampled line level. While SCL is released but a target still holds the line low, the high phase is frozen. This is how clock stretching is honoured. Two single-cycle strobes mark the first cycle of each low phase and of each high phase, so a byte engine can change or sample SDA in step with SCL.

The timing inputs are captured into a shadow copy at two moments: when the block is enabled, and at the end of every high phase. A change therefore never alters a phase that is already running. When the block is disabled, SCL is released at once and the sequencer returns to its idle state.

The sequencer has three states:
- OFF: idle, SCL released.
- LOW: SCL driven low.
- HIGH: SCL released.

It has these transitions:
- OFF→LOW on enable.
- LOW→HIGH when the last low tick completes.
- HIGH→LOW when the last high tick completes. This is the period boundary, where new timing is taken.
- LOW→OFF and HIGH→OFF when enable is removed.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, scl_pull_low, hi_start and lo_start are all 0.
- R2: While en is 0, scl_pull_low, hi_start and lo_start stay 0, whatever the timing inputs are. Disabling takes effect one clock after en is sampled low.
- R3: In the first cycle after en is sampled high from idle, scl_pull_low is 1 and lo_start is 1. Every period begins with the low phase.
- R4: The low phase, with scl_pull_low at 1, lasts (lo_len + 1) × 2^base_exp bus clocks.
- R5: If the line is not held by a target, the high phase, with scl_pull_low at 0, lasts (hi_len + 1) × 2^base_exp bus clocks.
- R6: A phase field of 0 still gives one prescaled tick. With base_exp = hi_len = lo_len = 0, SCL toggles every clock.
- R7: hi_start is 1 only in the first cycle of a high phase, and lo_start is 1 only in the first cycle of a low phase. The two are never 1 together.
- R8: During the high phase, every bus clock edge that samples scl_sense at 0 is a stall. Neither the prescaler nor the phase count advances, so the high phase grows by one clock per stall.
- R9: A change on base_exp, hi_len or lo_len takes effect only at the next start of a low phase. It first applies to the low phase that follows the current high phase.
- R10: If en is removed in mid-phase and then restored, the block restarts with a complete low phase of the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the SCL generator |
| base_exp | input | EXP_W (4) | Prescaler exponent; one tick every 2^base_exp clocks |
| hi_len | input | FIELD_W (4) | High phase length in ticks, minus one |
| lo_len | input | FIELD_W (4) | Low phase length in ticks, minus one |
| scl_sense | input | 1 | Sampled SCL line level (1 = high) |
| scl_pull_low | output | 1 | Request to drive SCL low |
| hi_start | output | 1 | Strobe on the first cycle of a high phase |
| lo_start | output | 1 | Strobe on the first cycle of a low phase |

## Verification
The phase lengths are measured over a table of exponent and field combinations:
- all-zero fields, which show that a zero field still yields one tick;
- full-scale fields;
- unequal high and low lengths, which would expose swapped fields;
- exponents from 0 to 4, which separate an error in the prescaler from an error in the phase count.

Directed cases cover three further points. A target holding the line partway through a high phase must lengthen that phase by exactly the held cycles. New timing written during a low phase must leave the current period untouched. A disable in mid-phase must release SCL at once and, on re-enable, start a clean low phase.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;
endpackage

// File: rtl/scl_timing_shadow.sv
module scl_timing_shadow #(
    parameter int EXP_W   = 4,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [EXP_W-1:0]   base_in,
    input  logic [FIELD_W-1:0] hi_in,
    input  logic [FIELD_W-1:0] lo_in,
    output logic [EXP_W-1:0]   base_q,
    output logic [FIELD_W-1:0] hi_q,
    output logic [FIELD_W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else if (load) begin
            base_q <= base_in;
            hi_q   <= hi_in;
            lo_q   <= lo_in;
        end
    end

    // Timing only moves at a load point (period boundary or enable)
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(base_q) && $stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [EXP_W-1:0] base,
    output logic             tick
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;
    logic             wrap;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << base);
        wrap = (cnt == mask);
        tick = run && !hold && wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!hold) begin
            if (wrap) cnt <= '0;
            else      cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= mask));
    assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold) |=> $stable(cnt));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_div_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               scl_sense,
    input  logic [FIELD_W-1:0] hi_len,
    input  logic [FIELD_W-1:0] lo_len,
    output logic               load,
    output logic               run,
    output logic               hold,
    output logic               scl_pull_low,
    output logic               hi_start,
    output logic               lo_start
);
    scl_phase_e         state, nxt;
    logic [FIELD_W-1:0] ph_cnt;
    logic               low_done, high_done;

    always_comb begin
        low_done  = tick && (ph_cnt == lo_len);
        high_done = tick && (ph_cnt == hi_len);
        run       = (state != PH_OFF);
        hold      = (state == PH_HIGH) && !scl_sense;
        nxt       = state;
        unique case (state)
            PH_OFF:  if (en) nxt = PH_LOW;
            PH_LOW:  if (!en) nxt = PH_OFF;
                     else if (low_done) nxt = PH_HIGH;
            PH_HIGH: if (!en) nxt = PH_OFF;
                     else if (high_done) nxt = PH_LOW;
            default: nxt = PH_OFF;
        endcase
        load = en && ((state == PH_OFF) || ((state == PH_HIGH) && high_done));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_OFF;
        else        state <= nxt;
    end

    // Tick count inside the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state) ph_cnt <= '0;
        else if (tick)              ph_cnt <= ph_cnt + 1'b1;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pull_low <= 1'b0;
            hi_start     <= 1'b0;
            lo_start     <= 1'b0;
        end else begin
            scl_pull_low <= (nxt == PH_LOW);
            hi_start     <= (nxt == PH_HIGH) && (state != PH_HIGH);
            lo_start     <= (nxt == PH_LOW) && (state != PH_LOW);
        end
    end

    assert_low_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOW) |-> (ph_cnt <= lo_len));
    assert_high_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |-> (ph_cnt <= hi_len));
    assert_stretch_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH && !scl_sense && en) |=> $stable(ph_cnt));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
    parameter int EXP_W   = 4,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [EXP_W-1:0]   base_exp,
    input  logic [FIELD_W-1:0] hi_len,
    input  logic [FIELD_W-1:0] lo_len,
    input  logic               scl_sense,
    output logic               scl_pull_low,
    output logic               hi_start,
    output logic               lo_start
);
    logic               load, run, hold, tick;
    logic [EXP_W-1:0]   base_q;
    logic [FIELD_W-1:0] hi_q, lo_q;

    scl_timing_shadow #(.EXP_W(EXP_W), .FIELD_W(FIELD_W)) shadow_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base_in(base_exp), .hi_in(hi_len), .lo_in(lo_len),
        .base_q(base_q), .hi_q(hi_q), .lo_q(lo_q)
    );

    scl_prescaler #(.EXP_W(EXP_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
        .base(base_q), .tick(tick)
    );

    scl_phase_fsm #(.FIELD_W(FIELD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .scl_sense(scl_sense),
        .hi_len(hi_q), .lo_len(lo_q), .load(load), .run(run), .hold(hold),
        .scl_pull_low(scl_pull_low), .hi_start(hi_start), .lo_start(lo_start)
    );

    assert_off_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull_low && !hi_start && !lo_start));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_start && lo_start));
    assert_high_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_start |-> (!scl_pull_low && $past(scl_pull_low)));
    assert_low_strobe_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_start |-> scl_pull_low);
endmodule

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] base_exp = '0, hi_len = '0, lo_len = '0;
    logic       target_hold = 1'b0;
    logic       scl_sense, scl_pull_low, hi_start, lo_start;
    int         checks = 0, errors = 0, cyc = 0;

    // Open-drain line: low if this side pulls or a target holds
    assign scl_sense = !scl_pull_low && !target_hold;

    always #2 clk = ~clk;

    scl_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .base_exp(base_exp),
        .hi_len(hi_len), .lo_len(lo_len), .scl_sense(scl_sense),
        .scl_pull_low(scl_pull_low), .hi_start(hi_start), .lo_start(lo_start)
    );

    // Fields: base[43:40] hi[39:36] lo[35:32] low_cycles[31:16] high_cycles[15:0]
    localparam logic [43:0] VEC [0:7] = '{
        {4'd0, 4'd0,  4'd0,  16'd1,  16'd1},
        {4'd0, 4'd3,  4'd2,  16'd3,  16'd4},
        {4'd1, 4'd4,  4'd3,  16'd8,  16'd10},
        {4'd2, 4'd1,  4'd1,  16'd8,  16'd8},
        {4'd3, 4'd0,  4'd5,  16'd48, 16'd8},
        {4'd0, 4'd15, 4'd15, 16'd16, 16'd16},
        {4'd4, 4'd2,  4'd1,  16'd32, 16'd48},
        {4'd1, 4'd7,  4'd6,  16'd14, 16'd16}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic wait_lo_start();
        for (int i = 0; i < 20000 && !lo_start; i++) @(negedge clk);
    endtask

    // Starts at a negedge showing lo_start; ends at the next such negedge
    task automatic run_period(output int nlo, output int nhi);
        nlo = 0;
        while (scl_pull_low && nlo < 20000) begin nlo++; @(negedge clk); end
        chk(hi_start, "R7 hi_start at high entry", int'(hi_start), 1);
        nhi = 0;
        while (!scl_pull_low && nhi < 20000) begin nhi++; @(negedge clk); end
        chk(lo_start, "R7 lo_start at low entry", int'(lo_start), 1);
    endtask

    initial begin
        int nlo, nhi;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!scl_pull_low && !hi_start && !lo_start, "R1 outputs idle in reset",
            int'({scl_pull_low, hi_start, lo_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_pull_low && !hi_start && !lo_start, "R1 outputs idle after reset",
            int'({scl_pull_low, hi_start, lo_start}), 0);

        // R2 disabled: timing inputs have no effect
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                base_exp = 4'(i); hi_len = 4'(i * 3); lo_len = 4'(i * 5);
                @(negedge clk);
                if (scl_pull_low || hi_start || lo_start) seen++;
            end
            chk(seen == 0, "R2 disabled stays idle", seen, 0);
        end

        // Vector table: R3, R4, R5, R6, R7
        for (int v = 0; v < 8; v++) begin
            en = 1'b0;
            base_exp = VEC[v][43:40]; hi_len = VEC[v][39:36]; lo_len = VEC[v][35:32];
            repeat (2) @(negedge clk);
            en = 1'b1;
            @(negedge clk);
            chk(lo_start && scl_pull_low, "R3 low phase first after enable",
                int'({lo_start, scl_pull_low}), 3);
            run_period(nlo, nhi);
            chk(nlo == int'(VEC[v][31:16]), (v == 0) ? "R6 R4 low length" : "R4 low length",
                nlo, int'(VEC[v][31:16]));
            chk(nhi == int'(VEC[v][15:0]), (v == 0) ? "R6 R5 high length" : "R5 high length",
                nhi, int'(VEC[v][15:0]));
        end

        // R8 stretch: base 1, hi 2 -> 6 cycles plus 5 stalls
        en = 1'b0; base_exp = 4'd1; hi_len = 4'd2; lo_len = 4'd1;
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        while (scl_pull_low) @(negedge clk);
        begin
            int m = 0;
            target_hold = 1'b1;
            while (!scl_pull_low && m < 20000) begin
                m++;
                if (m == 6) target_hold = 1'b0;
                @(negedge clk);
            end
            chk(m == 11, "R8 stretched high length", m, 11);
        end

        // R9 timing change in mid-low affects only the next period
        en = 1'b0; base_exp = 4'd0; hi_len = 4'd1; lo_len = 4'd1;
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        hi_len = 4'd3; lo_len = 4'd4;
        run_period(nlo, nhi);
        chk(nlo == 2, "R9 current low unchanged", nlo, 2);
        chk(nhi == 2, "R9 current high unchanged", nhi, 2);
        run_period(nlo, nhi);
        chk(nlo == 5, "R9 new low applied", nlo, 5);
        chk(nhi == 4, "R9 new high applied", nhi, 4);

        // R10 disable mid-low, then re-enable
        en = 1'b0; hi_len = 4'd1; lo_len = 4'd3;
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!scl_pull_low, "R10 released after disable", int'(scl_pull_low), 0);
        en = 1'b1;
        wait_lo_start();
        run_period(nlo, nhi);
        chk(nlo == 4, "R10 full low after re-enable", nlo, 4);
        chk(nhi == 2, "R10 high after re-enable", nhi, 2);

        summary_and_end();
    end
endmodule